// File: doc/BRIEF.md
# Audio Serial-Port Clock Generator

This block produces the frame clock and the bit clock of a two-channel audio serial port when the port is the clock source. A two-bit speed selector chooses one of three sample-rate families or hands clocking to the far end. A ratio flag says that the master clock is the fast variant. In that case every divider sees a clock that is halved first. When the far end supplies the clocks, the block tri-states its clock pins through a low output-enable and drives both clocks low.

The core clock `clk_i` runs at twice the master-clock rate, so one master-clock period is two core cycles. This lets the bit clock run as fast as the master clock in the quad-speed, unprescaled case. All periods below are counted in `clk_i` cycles. A new speed or ratio setting is adopted only where a frame ends, so a running frame is never cut short. In clock-slave operation the block is idle. A master setting then takes hold on the next core edge and starts a new frame.

Top module: `audio_clkgen`

## Requirements
- R1: Speed code 2'b11 on `mode_i`, once adopted, makes `clk_oe_o`, `lrck_o` and `sclk_o` all low and keeps them low.
- R2: Master speed codes 2'b00, 2'b01 and 2'b10 give an `lrck_o` period of 512, 256 and 128 `clk_i` cycles when `fast_mclk_i` is 0. These are master-clock/frame ratios of 256, 128 and 64.
- R3: Every `lrck_o` period holds exactly 64 `sclk_o` periods, and each `sclk_o` period is high for half of its length.
- R4: `lrck_o` is low for the first half of each frame and high for the second half.
- R5: Each `lrck_o` edge coincides with a falling edge of `sclk_o`. The first `sclk_o` rise in a frame comes half a bit period after the frame starts.
- R6: With `fast_mclk_i` at 1, every master-mode period doubles. The ratios become 512, 256 and 128, and `sclk_o` never changes on two consecutive cycles.
- R7: While `rst_n` is low, `clk_oe_o`, `lrck_o` and `sclk_o` are held low. After release, the first clock edge adopts the inputs, and a frame starts from zero.
- R8: A change of `mode_i` or `fast_mclk_i` in mid-frame has no effect until the current frame ends. The next frame starts from zero under the new setting.
- R9: When the adopted setting is clock-slave, a master code on `mode_i` drives `clk_oe_o` high one cycle later, with both clocks low at the start of the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock at twice the master-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset; low holds the block idle |
| mode_i | input | 2 | Speed code: 00 single, 01 double, 10 quad (clock master), 11 clock slave |
| fast_mclk_i | input | 1 | 1 when the master clock is the fast variant; inserts a divide-by-two |
| lrck_o | output | 1 | Frame clock, low for the left half of the frame |
| sclk_o | output | 1 | Bit clock, 64 periods per frame |
| clk_oe_o | output | 1 | Output enable for both clock pins; low means tri-stated |

## Verification
The hardest case to reach is a setting change that lands at an arbitrary point inside a frame, including one that arrives on the last cycle before a boundary or toggles the prescale while the speed stays the same. The stimulus draws speed and ratio changes from a seeded random source at random cycles over thousands of cycles. A bench model of frame position checks every output on every cycle. Directed sequences change the setting just after a frame-clock rise and time the remainder of the old frame and the start of the new one.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_SLAVE  = 2'b11
  } spd_mode_e;
endpackage

// File: rtl/aclk_prescale.sv
// Produces the counting enable: every cycle normally, every other cycle
// when the fast master-clock variant is in use.
module aclk_prescale (
  input  logic clk_i,
  input  logic rst_n,
  input  logic run_i,
  input  logic fast_i,
  output logic tick_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)                ph_q <= 1'b0;
    else if (!run_i || !fast_i) ph_q <= 1'b0;
    else                       ph_q <= ~ph_q;
  end

  assign tick_o = run_i & (~fast_i | ph_q);
endmodule

// File: rtl/aclk_mode_ctrl.sv
// Holds the adopted speed and ratio; reloads only while idle or at a frame end.
module aclk_mode_ctrl
  import aclk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_n,
  input  logic [1:0] mode_i,
  input  logic      fast_i,
  input  logic      wrap_i,
  output spd_mode_e act_mode_o,
  output logic      act_fast_o
);
  logic load;

  assign load = (act_mode_o == SPD_SLAVE) | wrap_i;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      act_mode_o <= SPD_SLAVE;
      act_fast_o <= 1'b0;
    end else if (load) begin
      act_mode_o <= spd_mode_e'(mode_i);
      act_fast_o <= fast_i;
    end
  end
endmodule

// File: rtl/aclk_frame_cnt.sv
// Position within the frame, counted in prescaled ticks. The frame length
// halves with each speed step, so the wrap point is a shifted all-ones mask.
module aclk_frame_cnt #(
  parameter int unsigned POS_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [1:0]       spd_i,
  output logic [POS_W-1:0] pos_o,
  output logic             wrap_o
);
  logic [POS_W-1:0] mask;
  logic             at_last;

  assign mask    = {POS_W{1'b1}} >> spd_i;
  assign at_last = ((pos_o & mask) == mask);
  assign wrap_o  = tick_i & at_last;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       pos_o <= '0;
    else if (!run_i)  pos_o <= '0;
    else if (wrap_o)  pos_o <= '0;
    else if (tick_i)  pos_o <= pos_o + POS_W'(1);
  end
endmodule

// File: rtl/aclk_clk_sel.sv
// Picks the frame-clock and bit-clock taps of the position counter per speed.
module aclk_clk_sel #(
  parameter int unsigned POS_W   = 9,
  parameter int unsigned HALF_SH = 2
) (
  input  logic             run_i,
  input  logic [1:0]       spd_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             lrck_o,
  output logic             sclk_o
);
  localparam int unsigned NSPD = 4;
  logic [NSPD-1:0] lr_tap;
  logic [NSPD-1:0] bc_tap;

  for (genvar g = 0; g < NSPD; g++) begin : g_tap
    if (g < 3) begin : g_used
      assign lr_tap[g] = pos_i[POS_W-1-g];
      assign bc_tap[g] = pos_i[HALF_SH-g];
    end else begin : g_idle
      assign lr_tap[g] = 1'b0;
      assign bc_tap[g] = 1'b0;
    end
  end

  assign lrck_o = run_i & lr_tap[spd_i];
  assign sclk_o = run_i & bc_tap[spd_i];
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import aclk_pkg::*;
#(
  parameter int unsigned BITS_PER_FRAME = 64,
  parameter int unsigned HALF_SH        = 2
) (
  input  logic       clk_i,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       fast_mclk_i,
  output logic       lrck_o,
  output logic       sclk_o,
  output logic       clk_oe_o
);
  localparam int unsigned POS_W = $clog2(BITS_PER_FRAME) + 1 + HALF_SH;

  spd_mode_e        act_mode;
  logic             act_fast;
  logic             run;
  logic             tick;
  logic             wrap;
  logic [POS_W-1:0] pos;

  assign run      = (act_mode != SPD_SLAVE);
  assign clk_oe_o = run;

  aclk_mode_ctrl u_mode (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .fast_i     (fast_mclk_i),
    .wrap_i     (wrap),
    .act_mode_o (act_mode),
    .act_fast_o (act_fast)
  );

  aclk_prescale u_presc (
    .clk_i  (clk_i),
    .rst_n  (rst_n),
    .run_i  (run),
    .fast_i (act_fast),
    .tick_o (tick)
  );

  aclk_frame_cnt #(.POS_W(POS_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_n  (rst_n),
    .run_i  (run),
    .tick_i (tick),
    .spd_i  (act_mode),
    .pos_o  (pos),
    .wrap_o (wrap)
  );

  aclk_clk_sel #(.POS_W(POS_W), .HALF_SH(HALF_SH)) u_sel (
    .run_i  (run),
    .spd_i  (act_mode),
    .pos_i  (pos),
    .lrck_o (lrck_o),
    .sclk_o (sclk_o)
  );
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic clk_i,
  input logic rst_n,
  input logic lrck_o,
  input logic sclk_o,
  input logic clk_oe_o,
  input logic act_fast
);
  // R1: pins disabled means both clocks parked low
  p_slave_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    !clk_oe_o |-> (!lrck_o && !sclk_o));

  // R5: with the pins enabled throughout, a frame-clock edge comes with a bit-clock fall
  p_lr_on_bclk_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (clk_oe_o && $past(clk_oe_o) && !$stable(lrck_o)) |-> $fell(sclk_o));

  // R8: leaving master operation happens only at the end of a frame
  p_stop_at_frame_end_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(clk_oe_o) |-> ($past(lrck_o) && $past(sclk_o)));

  // R6: prescaled bit clock holds each level for at least two cycles
  p_fast_half_min_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (act_fast && clk_oe_o && $past(clk_oe_o) && !$stable(sclk_o)) |=> $stable(sclk_o));
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_n),
  .lrck_o   (lrck_o),
  .sclk_o   (sclk_o),
  .clk_oe_o (clk_oe_o),
  .act_fast (act_fast)
);

// File: tb/audio_clkgen_tb.sv
`timescale 1ns/1ps
module audio_clkgen_tb;
  localparam int BITS = 64;
  localparam int HSH  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       fast = 1'b0;
  logic       lrck, sclk, oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit model_on = 0;

  always #5 clk = ~clk;

  audio_clkgen #(.BITS_PER_FRAME(BITS), .HALF_SH(HSH)) u_dut (
    .clk_i(clk), .rst_n(rst_n), .mode_i(mode), .fast_mclk_i(fast),
    .lrck_o(lrck), .sclk_o(sclk), .clk_oe_o(oe)
  );

  function automatic int half_len(input int m, input int f);
    return (1 << (HSH - m)) * (f ? 2 : 1);
  endfunction
  function automatic int frame_len(input int m, input int f);
    return 2 * BITS * half_len(m, f);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Spec model of frame position, in core cycles since the frame began
  int m_mode = 3;
  int m_fast = 0;
  int m_c    = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 3; m_fast <= 0; m_c <= 0;
    end else if (m_mode == 3 || m_c == frame_len(m_mode, m_fast) - 1) begin
      m_mode <= int'(mode); m_fast <= int'(fast); m_c <= 0;
    end else begin
      m_c <= m_c + 1;
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      int e_oe, e_sc, e_lr, hp;
      e_oe = (m_mode != 3);
      hp   = e_oe ? half_len(m_mode, m_fast) : 1;
      e_sc = e_oe ? (m_c / hp) % 2 : 0;
      e_lr = e_oe ? (m_c / (BITS * hp)) % 2 : 0;
      chk(oe == e_oe[0],   "R1 enable",   oe,   e_oe);
      chk(sclk == e_sc[0], "R3 bitclk",   sclk, e_sc);
      chk(lrck == e_lr[0], "R2 frameclk", lrck, e_lr);
    end
  end

  task automatic set_cfg(input int m, input int f);
    @(negedge clk);
    mode = m[1:0];
    fast = f[0];
  endtask

  task automatic wait_lr_rise();
    logic pl;
    pl = lrck;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!pl && lrck) break;
      pl = lrck;
    end
  endtask

  // Time one frame from lrck rise to lrck rise
  task automatic measure(input int exp_per, input bit do_chk, input string req);
    int n, hi, rises;
    logic pl, ps;
    n = 0; hi = 0; rises = 0;
    wait_lr_rise();
    pl = lrck; ps = sclk;
    for (int i = 0; i < 5000; i++) begin
      if (lrck) hi++;
      @(negedge clk);
      n++;
      if (!ps && sclk) rises++;
      if (!pl && lrck) break;
      pl = lrck; ps = sclk;
    end
    if (do_chk) begin
      chk(n == exp_per, req, n, exp_per);
      chk(rises == BITS, "R3 bits per frame", rises, BITS);
      chk(hi == exp_per / 2, "R4 frame duty", hi, exp_per / 2);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    // R7: held idle in reset
    chk(oe == 1'b0,   "R7 oe in reset",   oe,   0);
    chk(lrck == 1'b0, "R7 lrck in reset", lrck, 0);
    chk(sclk == 1'b0, "R7 sclk in reset", sclk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(oe == 1'b1, "R7 adopt after release", oe, 1);
    chk(lrck == 1'b0 && sclk == 1'b0, "R7 frame starts at zero", {lrck, sclk}, 0);
    model_on = 1;

    // R2 / R6: periods of every master setting
    for (int f = 0; f < 2; f++) begin
      for (int m = 0; m < 3; m++) begin
        set_cfg(m, f);
        measure(frame_len(m, f), 0, "");
        measure(frame_len(m, f), 0, "");
        measure(frame_len(m, f), 1, f ? "R6 prescaled period" : "R2 frame period");
      end
    end

    // R8: change in mid-frame is deferred to the frame end
    set_cfg(0, 0);
    measure(512, 0, "");
    measure(512, 0, "");
    wait_lr_rise();
    mode = 2'b10;
    begin
      int n;
      n = 0;
      while (lrck && n < 5000) begin @(negedge clk); n++; end
      chk(n == 256, "R8 old frame completes", n, 256);
      n = 0;
      while (!sclk && n < 5000) begin @(negedge clk); n++; end
      chk(n == 1, "R5 first bit rise half a bit in", n, 1);
      while (!lrck && n < 5000) begin @(negedge clk); n++; end
      chk(n == 64, "R8 new frame restarts", n, 64);
    end

    // R5 in single speed: bit rise after frame start
    set_cfg(0, 0);
    measure(512, 0, "");
    begin
      int n;
      n = 0;
      while (lrck && n < 5000) begin @(negedge clk); n++; end
      n = 0;
      while (!sclk && n < 5000) begin @(negedge clk); n++; end
      chk(n == 4, "R5 first bit rise single", n, 4);
    end

    // R1 / R9: slave and back
    set_cfg(3, 0);
    repeat (1100) @(negedge clk);
    chk(oe == 1'b0, "R1 slave disables pins", oe, 0);
    chk(lrck == 1'b0 && sclk == 1'b0, "R1 slave clocks low", {lrck, sclk}, 0);
    set_cfg(1, 1);
    @(negedge clk);
    chk(oe == 1'b1, "R9 master resumes next cycle", oe, 1);
    chk(lrck == 1'b0 && sclk == 1'b0, "R9 frame starts low", {lrck, sclk}, 0);

    // Random setting changes at random cycles
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 199) == 0) begin
        mode = 2'($urandom_range(0, 3));
        fast = 1'($urandom_range(0, 1));
      end
    end

    // R7: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(oe == 1'b0 && lrck == 1'b0 && sclk == 1'b0, "R7 reset mid-run", {oe, lrck, sclk}, 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule